// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block decides which interrupt a 16-bit processor core services and runs the memory steps that go with entering and leaving a handler. It watches fourteen level-sensitive maskable request lines and one non-maskable request that fires on a rising edge. At an instruction boundary (the sequencer is idle) it picks a winner and saves the return context on the stack. It first writes the program counter supplied by the core, then the status word. It then clears the global enable and reads the handler address from a vector table. It hands that address to the core as a program-counter load.

A return request from the core runs the reverse steps. The saved status word is read back first, then the program counter. This restores the global enable to the state it had before entry. The block holds the status word, the stack pointer, the NMI enable bit and the NMI pending flag. The core reaches memory through one request/ready port. Every word transfer waits for the ready handshake, so memories with any number of wait states can be attached.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After a synchronous reset the stack pointer is 0x0252, the status word, NMI enable and NMI flag byte are all 0, `busy` is 0 and no memory request is made.
- R2: The maskable lines are ignored while bit 3 of the status word (global enable) is 0; with it at 1 any asserted line starts an entry.
- R3: When several maskable lines are asserted together, the highest-numbered one is taken and `vec_idx` reports its number (0 to 13).
- R4: Entry writes the program counter to SP-2, then the status word to SP-4, each on a `mem_rdy` handshake with `mem_we`=1. The SP then ends 4 lower and status bit 3 is cleared. The block next reads the word at 0xFFE0 + 2*index and pulses `pc_load` with `pc_out` equal to that word.
- R5: `vec_idx` keeps its value from acceptance until the vector read completes, whatever the request lines do meanwhile.
- R6: A return request in the idle state reads the status word at SP and then the program counter at SP+2, and raises the SP by 4. The status word (global enable included) takes the popped value, and `pc_load` pulses with the popped program counter.
- R7: The NMI is raised only by a 0-to-1 change of `nmi_in` between two clocks while NMI enable is 1. A level held high does not retrigger, and an edge seen while NMI enable is 0 is dropped.
- R8: A pending NMI is taken with index 14 ahead of all maskable lines, whatever the global enable holds.
- R9: Accepting an NMI clears NMI enable and sets bit 4 (value 0x10) of `nmi_flags`. While that bit is set, NMI edges are ignored. A `nmi_flag_clr` pulse clears it and a `nmie_set` pulse sets NMI enable.
- R10: An NMI edge that arrives while a sequence is running is held and taken as soon as the sequencer returns to idle, nesting over a maskable handler.
- R11: A return request takes priority over any pending interrupt in the same idle cycle, and its first memory access is a read.
- R12: `sr_wr` updates the status word only while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 14 | Maskable request lines, level sensitive |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| reti_req | input | 1 | Return-from-interrupt request pulse |
| sr_wr | input | 1 | Status word write strobe from the core |
| sr_wdata | input | 16 | Status word write data |
| nmie_set | input | 1 | Pulse that sets NMI enable |
| nmi_flag_clr | input | 1 | Pulse that clears the NMI pending flag |
| pc_in | input | 16 | Program counter to save on entry |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = stack write, 0 = read |
| mem_addr | output | 16 | Byte address of the transfer |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Transfer completes on a clock with mem_req and mem_rdy high |
| pc_load | output | 1 | One-cycle strobe: core loads pc_out |
| pc_out | output | 16 | Handler address or restored program counter |
| vec_idx | output | 4 | Index of the accepted interrupt (14 = NMI) |
| busy | output | 1 | Sequencer is running |
| sr_q | output | 16 | Current status word |
| sp_q | output | 16 | Current stack pointer |
| nmie | output | 1 | NMI enable |
| nmi_flags | output | 8 | Interrupt flag byte; bit 4 = NMI pending |

## Verification
The hardest case to reach is an NMI edge that lands while a maskable entry is still stepping through its stack writes. The request must be held across the sequence and then nested on top of the new handler. The bench reaches it by inserting three wait states per memory transfer and raising `nmi_in` as soon as `busy` rises. It then checks that two entries complete back to back, with the stack pointer 8 below its start, and that two returns bring it back. A second corner is a return request in the very cycle an NMI becomes pending. The bench places both with exact negedge timing and checks that the first memory access is a read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_PC = 3'd1,
    ST_PUSH_SR = 3'd2,
    ST_VEC     = 3'd3,
    ST_POP_SR  = 3'd4,
    ST_POP_PC  = 3'd5
  } seq_state_t;

endpackage

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NUM_IRQ = 14,
  parameter int IW      = 4
) (
  input  logic [NUM_IRQ-1:0] req,
  output logic               vld,
  output logic [IW-1:0]      idx
);

  // Later iterations overwrite earlier ones: highest line number wins.
  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (req[i]) idx = IW'(i);
    end
    vld = |req;
  end

endmodule

// File: rtl/irqc_nmi.sv
module irqc_nmi (
  input  logic clk,
  input  logic rst,
  input  logic nmi_in,
  input  logic accept,
  input  logic nmie_set,
  input  logic flag_clr,
  output logic req_q,
  output logic nmie_q,
  output logic flag_q
);

  logic nmi_q;
  logic rise;

  assign rise = nmi_in & ~nmi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q  <= 1'b0;
      req_q  <= 1'b0;
      nmie_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      nmi_q <= nmi_in;
      if (accept) begin
        req_q  <= 1'b0;
        nmie_q <= 1'b0;
        flag_q <= 1'b1;
      end else begin
        if (rise && nmie_q && !flag_q) req_q <= 1'b1;
        if (nmie_set) nmie_q <= 1'b1;
        if (flag_clr) flag_q <= 1'b0;
      end
    end
  end

  AST_NMIE_DROP: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> !nmie_q); // R9

  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> ($past(nmi_in) && $past(nmie_q) && !$past(flag_q))); // R7

endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
  import irqc_pkg::*;
#(
  parameter int              DW       = 16,
  parameter int              NUM_IRQ  = 14,
  parameter int              IW       = 4,
  parameter logic [DW-1:0]   SP_RESET = 16'h0252,
  parameter logic [DW-1:0]   VEC_BASE = 16'hFFE0,
  parameter int              GIE_BIT  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reti_req,
  input  logic          sr_wr,
  input  logic [DW-1:0] sr_wdata,
  input  logic [DW-1:0] pc_in,
  input  logic          irq_vld,
  input  logic [IW-1:0] irq_idx,
  input  logic          nmi_req,
  output logic          nmi_accept,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic          pc_load,
  output logic [DW-1:0] pc_out,
  output logic [IW-1:0] vec_idx,
  output logic          busy,
  output logic [DW-1:0] sr_q,
  output logic [DW-1:0] sp_q
);

  localparam logic [IW-1:0] NMI_IDX = IW'(NUM_IRQ);
  localparam logic [DW-1:0] WSTEP   = DW'(2);

  seq_state_t    state_q;
  logic [DW-1:0] pc_hold;
  logic          idle, hs, gie;
  logic          start_ret, take_nmi, take_irq, in_entry;

  assign idle      = (state_q == ST_IDLE);
  assign gie       = sr_q[GIE_BIT];
  assign hs        = mem_req && mem_rdy;
  assign start_ret = idle && reti_req;
  assign take_nmi  = idle && !reti_req && nmi_req;
  assign take_irq  = idle && !reti_req && !nmi_req && gie && irq_vld;
  assign in_entry  = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_SR) ||
                     (state_q == ST_VEC);
  assign nmi_accept = take_nmi;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      vec_idx <= '0;
      pc_hold <= '0;
      sr_q    <= '0;
      sp_q    <= SP_RESET;
      pc_out  <= '0;
      pc_load <= 1'b0;
    end else begin
      pc_load <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (sr_wr) sr_q <= sr_wdata;
          if (start_ret) begin
            state_q <= ST_POP_SR;
          end else if (take_nmi) begin
            vec_idx <= NMI_IDX;
            pc_hold <= pc_in;
            state_q <= ST_PUSH_PC;
          end else if (take_irq) begin
            vec_idx <= irq_idx;
            pc_hold <= pc_in;
            state_q <= ST_PUSH_PC;
          end
        end
        ST_PUSH_PC: if (hs) begin
          sp_q    <= sp_q - WSTEP;
          state_q <= ST_PUSH_SR;
        end
        ST_PUSH_SR: if (hs) begin
          sp_q          <= sp_q - WSTEP;
          sr_q[GIE_BIT] <= 1'b0;
          state_q       <= ST_VEC;
        end
        ST_VEC: if (hs) begin
          pc_out  <= mem_rdata;
          pc_load <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_POP_SR: if (hs) begin
          sr_q    <= mem_rdata;
          sp_q    <= sp_q + WSTEP;
          state_q <= ST_POP_PC;
        end
        ST_POP_PC: if (hs) begin
          pc_out  <= mem_rdata;
          pc_load <= 1'b1;
          sp_q    <= sp_q + WSTEP;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = !idle;
    mem_we    = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_SR);
    mem_wdata = (state_q == ST_PUSH_PC) ? pc_hold : sr_q;
    case (state_q)
      ST_PUSH_PC, ST_PUSH_SR: mem_addr = sp_q - WSTEP;
      ST_VEC:                 mem_addr = VEC_BASE + (DW'(vec_idx) << 1);
      default:                mem_addr = sp_q;
    endcase
    busy = !idle;
  end

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    (hs && mem_we) |=> (sp_q == $past(sp_q) - WSTEP)); // R4

  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    (hs && !mem_we && state_q != ST_VEC) |=> (sp_q == $past(sp_q) + WSTEP)); // R6

  AST_GIE_LOW_AT_VEC: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_VEC) |-> !sr_q[GIE_BIT]); // R4

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_entry && $past(in_entry)) |-> $stable(vec_idx)); // R5

  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (rst)
    (idle && !reti_req && nmi_req) |=> (vec_idx == NMI_IDX && mem_we)); // R8

  AST_RETI_FIRST: assert property (@(posedge clk) disable iff (rst)
    (idle && reti_req) |=> (mem_req && !mem_we)); // R11

  AST_SR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (!idle && state_q != ST_POP_SR && state_q != ST_PUSH_SR) |=> $stable(sr_q)); // R12

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int            NUM_IRQ      = 14,
  parameter int            DW           = 16,
  parameter int            IW           = $clog2(NUM_IRQ + 1),
  parameter logic [DW-1:0] SP_RESET     = 16'h0252,
  parameter logic [DW-1:0] VEC_BASE     = 16'hFFE0,
  parameter int            GIE_BIT      = 3,
  parameter int            NMI_FLAG_BIT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               nmi_in,
  input  logic               reti_req,
  input  logic               sr_wr,
  input  logic [DW-1:0]      sr_wdata,
  input  logic               nmie_set,
  input  logic               nmi_flag_clr,
  input  logic [DW-1:0]      pc_in,
  output logic               mem_req,
  output logic               mem_we,
  output logic [DW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  input  logic               mem_rdy,
  output logic               pc_load,
  output logic [DW-1:0]      pc_out,
  output logic [IW-1:0]      vec_idx,
  output logic               busy,
  output logic [DW-1:0]      sr_q,
  output logic [DW-1:0]      sp_q,
  output logic               nmie,
  output logic [7:0]         nmi_flags
);

  logic          irq_vld;
  logic [IW-1:0] irq_idx;
  logic          nmi_req, nmi_accept, nmi_flag;

  irqc_prio #(.NUM_IRQ(NUM_IRQ), .IW(IW)) u_prio (
    .req (irq_req),
    .vld (irq_vld),
    .idx (irq_idx)
  );

  irqc_nmi u_nmi (
    .clk      (clk),
    .rst      (rst),
    .nmi_in   (nmi_in),
    .accept   (nmi_accept),
    .nmie_set (nmie_set),
    .flag_clr (nmi_flag_clr),
    .req_q    (nmi_req),
    .nmie_q   (nmie),
    .flag_q   (nmi_flag)
  );

  irqc_seq #(
    .DW(DW), .NUM_IRQ(NUM_IRQ), .IW(IW),
    .SP_RESET(SP_RESET), .VEC_BASE(VEC_BASE), .GIE_BIT(GIE_BIT)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .reti_req   (reti_req),
    .sr_wr      (sr_wr),
    .sr_wdata   (sr_wdata),
    .pc_in      (pc_in),
    .irq_vld    (irq_vld),
    .irq_idx    (irq_idx),
    .nmi_req    (nmi_req),
    .nmi_accept (nmi_accept),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_rdy    (mem_rdy),
    .pc_load    (pc_load),
    .pc_out     (pc_out),
    .vec_idx    (vec_idx),
    .busy       (busy),
    .sr_q       (sr_q),
    .sp_q       (sp_q)
  );

  always_comb begin
    nmi_flags               = '0;
    nmi_flags[NMI_FLAG_BIT] = nmi_flag;
  end

  AST_HIGHEST_LINE: assert property (@(posedge clk) disable iff (rst)
    irq_vld |-> ((irq_req >> irq_idx) == NUM_IRQ'(1))); // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!mem_req && sp_q == SP_RESET && nmi_flags == 8'h00)); // R1

endmodule

// File: tb/test_irq_entry_ctrl.sv
`timescale 1ns/1ps
module test_irq_entry_ctrl;

  localparam int NUM_IRQ = 14;

  logic               clk = 1'b0;
  logic               rst;
  logic [NUM_IRQ-1:0] irq_req;
  logic               nmi_in, reti_req, sr_wr, nmie_set, nmi_flag_clr;
  logic [15:0]        sr_wdata, pc_in;
  logic               mem_req, mem_we, mem_rdy, pc_load, busy, nmie;
  logic [15:0]        mem_addr, mem_wdata, mem_rdata, pc_out, sr_q, sp_q;
  logic [3:0]         vec_idx;
  logic [7:0]         nmi_flags;

  int n_checks = 0;
  int n_fail   = 0;
  int ws       = 0;
  int wcnt     = 0;
  bit done     = 0;
  logic [15:0] mem [0:255];

  always #2 clk = ~clk;

  irq_entry_ctrl i_irq_entry_ctrl (
    .clk(clk), .rst(rst), .irq_req(irq_req), .nmi_in(nmi_in),
    .reti_req(reti_req), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .nmie_set(nmie_set), .nmi_flag_clr(nmi_flag_clr), .pc_in(pc_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .pc_load(pc_load), .pc_out(pc_out), .vec_idx(vec_idx), .busy(busy),
    .sr_q(sr_q), .sp_q(sp_q), .nmie(nmie), .nmi_flags(nmi_flags)
  );

  // Memory model with a programmable number of wait states
  always @(posedge clk) begin
    if (mem_req && mem_rdy) begin
      if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
      wcnt <= 0;
    end else if (mem_req) wcnt <= wcnt + 1;
    else wcnt <= 0;
  end

  always @(negedge clk) begin
    mem_rdy   <= mem_req && (wcnt >= ws);
    mem_rdata <= mem[mem_addr[8:1]];
  end

  function automatic logic [15:0] vec_word(input int i);
    return 16'hC000 + 16'(i * 16);
  endfunction

  function automatic int mi(input logic [15:0] a);
    return int'(a[8:1]);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pcload(output bit got);
    got = 0;
    for (int i = 0; i < 300 && !got; i++) begin
      @(negedge clk);
      if (pc_load) got = 1;
    end
  endtask

  task automatic pulse_reti();
    reti_req = 1; @(negedge clk); reti_req = 0;
  endtask

  task automatic write_sr(input logic [15:0] v);
    sr_wdata = v; sr_wr = 1; @(negedge clk); sr_wr = 0;
  endtask

  task automatic pulse_nmie_set();
    nmie_set = 1; @(negedge clk); nmie_set = 0;
  endtask

  task automatic pulse_flag_clr();
    nmi_flag_clr = 1; @(negedge clk); nmi_flag_clr = 0;
  endtask

  task automatic t_reset();
    chk(sp_q == 16'h0252, "R1 sp after reset", sp_q, 16'h0252);
    chk(sr_q == 16'h0000, "R1 sr after reset", sr_q, 0);
    chk(!busy && !mem_req, "R1 idle after reset", {busy, mem_req}, 0);
    chk(!nmie && nmi_flags == 8'h00, "R1 nmi state after reset", {nmie, nmi_flags}, 0);
  endtask

  task automatic t_masked();
    irq_req = '1;
    cyc(10);
    chk(!busy && !mem_req, "R2 masked lines ignored with GIE=0", busy, 0);
    irq_req = '0;
    cyc(2);
  endtask

  task automatic t_line(input int k, input int wsv);
    bit got;
    logic [15:0] pcv;
    ws  = wsv;
    pcv = 16'h4000 + 16'(k);
    pc_in = pcv;
    write_sr(16'h010D);
    irq_req = NUM_IRQ'((1 << (k + 1)) - 1);
    wait_pcload(got);
    irq_req = '0;
    chk(got, "R4 entry completes", got, 1);
    chk(vec_idx == 4'(k), "R3 R5 highest line index", vec_idx, k);
    chk(pc_out == vec_word(k), "R4 vector word loaded", pc_out, vec_word(k));
    chk(sp_q == 16'h024E, "R4 sp after entry", sp_q, 16'h024E);
    chk(sr_q[3] == 1'b0, "R4 GIE cleared", sr_q, 16'h0105);
    chk(mem[mi(16'h0250)] == pcv, "R4 pc pushed first", mem[mi(16'h0250)], pcv);
    chk(mem[mi(16'h024E)] == 16'h010D, "R4 sr pushed second", mem[mi(16'h024E)], 16'h010D);
    cyc(2);
    pulse_reti();
    wait_pcload(got);
    chk(got && pc_out == pcv, "R6 pc restored", pc_out, pcv);
    chk(sp_q == 16'h0252, "R6 sp restored", sp_q, 16'h0252);
    chk(sr_q == 16'h010D, "R6 sr and GIE restored", sr_q, 16'h010D);
    cyc(2);
  endtask

  task automatic t_nmi_over();
    bit got;
    ws = 1;
    pulse_nmie_set();
    write_sr(16'h0000);
    irq_req = '1;
    nmi_in = 1;
    wait_pcload(got);
    irq_req = '0;
    chk(got && vec_idx == 4'd14, "R8 NMI index over all lines", vec_idx, 14);
    chk(pc_out == vec_word(14), "R8 NMI vector", pc_out, vec_word(14));
    chk(!nmie, "R9 NMI enable cleared", nmie, 0);
    chk(nmi_flags == 8'h10, "R9 pending flag bit 4", nmi_flags, 8'h10);
    pulse_reti();
    wait_pcload(got);
    chk(sp_q == 16'h0252, "R6 sp after NMI return", sp_q, 16'h0252);
    cyc(2);
  endtask

  task automatic t_nmi_ignore();
    bit got;
    pulse_nmie_set();
    nmi_in = 0; cyc(2); nmi_in = 1;
    cyc(8);
    chk(!busy, "R9 edge ignored while flag set", busy, 0);
    pulse_flag_clr();
    cyc(8);
    chk(!busy, "R7 held level does not retrigger", busy, 0);
    chk(nmi_flags == 8'h00, "R9 flag cleared by pulse", nmi_flags, 0);
    nmi_in = 0; cyc(2); nmi_in = 1;
    wait_pcload(got);
    chk(got && vec_idx == 4'd14, "R7 fresh edge taken", vec_idx, 14);
    pulse_reti();
    wait_pcload(got);
    pulse_flag_clr();
    nmi_in = 0; cyc(2); nmi_in = 1;
    cyc(8);
    chk(!busy, "R7 edge dropped with NMI enable 0", busy, 0);
    nmi_in = 0;
    cyc(2);
  endtask

  task automatic t_nested();
    bit got;
    int guard;
    ws = 3;
    pulse_nmie_set();
    pc_in = 16'h5A5A;
    write_sr(16'h010D);
    irq_req = NUM_IRQ'(4);
    guard = 0;
    while (!busy && guard < 50) begin @(negedge clk); guard++; end
    nmi_in = 1;
    sr_wdata = 16'hFFFF; sr_wr = 1;
    @(negedge clk);
    sr_wr = 0;
    chk(sr_q != 16'hFFFF, "R12 sr write ignored while busy", sr_q, 16'h010D);
    chk(vec_idx == 4'd2, "R5 index held during entry", vec_idx, 2);
    wait_pcload(got);
    irq_req = '0;
    chk(got && pc_out == vec_word(2), "R10 maskable entry completes first", pc_out, vec_word(2));
    wait_pcload(got);
    chk(got && vec_idx == 4'd14, "R10 held NMI nests", vec_idx, 14);
    chk(sp_q == 16'h024A, "R10 two frames on stack", sp_q, 16'h024A);
    nmi_in = 0;
    pulse_reti();
    wait_pcload(got);
    chk(sp_q == 16'h024E, "R6 first return", sp_q, 16'h024E);
    pulse_reti();
    wait_pcload(got);
    chk(sp_q == 16'h0252 && sr_q == 16'h010D, "R6 second return", sp_q, 16'h0252);
    chk(pc_out == 16'h5A5A, "R6 outer pc restored", pc_out, 16'h5A5A);
    pulse_flag_clr();
    cyc(2);
  endtask

  task automatic t_reti_prio();
    bit got;
    ws = 0;
    pulse_nmie_set();
    nmi_in = 1;
    @(negedge clk);
    reti_req = 1;
    @(negedge clk);
    reti_req = 0;
    chk(mem_req && !mem_we && mem_addr == 16'h0252, "R11 return wins, read first",
        {mem_req, mem_we, mem_addr}, {2'b10, 16'h0252});
    wait_pcload(got);
    chk(sp_q == 16'h0256, "R11 return ran", sp_q, 16'h0256);
    wait_pcload(got);
    chk(got && vec_idx == 4'd14, "R10 NMI taken after return", vec_idx, 14);
    nmi_in = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 0; i <= NUM_IRQ; i++) mem[mi(16'hFFE0 + 16'(2 * i))] = vec_word(i);
    rst = 1; irq_req = '0; nmi_in = 0; reti_req = 0; sr_wr = 0; sr_wdata = '0;
    nmie_set = 0; nmi_flag_clr = 0; pc_in = '0;
    cyc(4);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_masked();
    for (int k = 0; k < NUM_IRQ; k++) t_line(k, k % 3);
    t_nmi_over();
    t_nmi_ignore();
    t_nested();
    t_reti_prio();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule